// File: doc/BRIEF.md
# Receive Buffer Descriptor Engine

This block takes received frames from a byte stream and scatters them over a ring of receive buffer descriptors in system memory. Every frame is announced by a header carrying its byte count and then delivered byte by byte. Before the block writes anything, it walks the ring from its current slot. It confirms that enough empty descriptors are available to hold the frame plus four trailing check bytes. If the space is there, it fills the buffers in turn and appends a standard CRC-32. It then writes each descriptor back with its byte count and status, and raises a pulse per finished buffer and per finished frame.

A descriptor takes two 32-bit words. The first holds a status field in bits 31:16 and a byte count in bits 15:0. The second holds the buffer address. Reception is armed by a doorbell that samples the empty bit of the current descriptor. After each frame the block re-arms itself from the next descriptor. Two length limits apply. A hard cap truncates oversize frames, and a soft, software-set limit only marks the frame as too long.

Top module: `rxbd_engine`

## Requirements
- R1: After reset, `rx_active`, `hdr_ready`, `mem_req`, `evt_buf` and `evt_frame` are all 0.
- R2: While the block is enabled, idle and not active, a doorbell reads word 0 of the current descriptor. `rx_active` then takes the empty bit, which is status bit 15, found at word bit 31.
- R3: With `cfg_enable` low, `rx_active` is 0 one cycle later, and a doorbell has no effect.
- R4: Each empty descriptor found from the current slot counts as one maximum-size buffer, and a frame is accepted when the total reaches its stored size. A frame that meets a non-empty descriptor first is dropped whole: its bytes are consumed, nothing is written to memory, no event is raised, and the current slot does not move.
- R5: Each buffer receives min(remaining, buffer size) bytes at its address plus offset. A byte write drives lane `addr[1:0]` of `mem_wdata` and sets only that bit of `mem_be`. The write-back stores that count in bits 15:0, clears the empty bit and keeps the wrap bit.
- R6: The stored size is the frame length plus 4. The four check bytes follow the data, lowest byte first, and may straddle two buffers. They are the complemented reflected CRC-32 (polynomial 0xEDB88320, preset all ones) over the stored data bytes.
- R7: The last descriptor of a frame gets status bit 11 and one `evt_frame` pulse. Every earlier descriptor gives one `evt_buf` pulse instead.
- R8: A stored size above `HARD_CAP` is cut to `HARD_CAP`, so `HARD_CAP`-4 data bytes are kept. The last descriptor gets status bits 0 and 5, and the excess input bytes are consumed and discarded.
- R9: A stored size above `cfg_max_len` sets status bit 5 only. A size equal to the limit sets no flag.
- R10: A descriptor with status bit 13 set is followed by the ring base; any other descriptor is followed by its own address plus 8.
- R11: The buffer size register keeps bits 10:4 of the written value. A value that masks to zero selects 0x7F0, which is also the reset value.
- R12: After a frame, `rx_active` equals the empty bit of the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Controller enable |
| cfg_max_len | input | LEN_W | Soft length limit, counted in stored bytes |
| ring_base_wr | input | 1 | Loads the ring base and the current slot |
| ring_base_data | input | ADDR_W-3 | Ring base in units of 8 bytes |
| bufsz_wr | input | 1 | Writes the buffer size register |
| bufsz_data | input | BSZ_W | Buffer size value |
| doorbell | input | 1 | Receive doorbell |
| hdr_valid | input | 1 | Frame header valid |
| hdr_len | input | LEN_W | Frame length in bytes, without check bytes |
| hdr_ready | output | 1 | Header accepted |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_ready | output | 1 | Frame byte accepted |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | One-cycle acknowledge |
| rx_active | output | 1 | Reception active |
| evt_buf | output | 1 | Buffer completed pulse |
| evt_frame | output | 1 | Frame completed pulse |

## Verification
The doorbell and a frame header can arrive in the same cycle. The doorbell can also arrive while the block is busy with a frame's data. The bench raises the doorbell together with a header while reception is inactive, and again part-way through a frame's bytes. Both times it judges the outcome by complete frame contents, the memory write count, and `rx_active` afterwards. The header must wait until the doorbell has armed reception, and the doorbell raised during the frame must leave no trace.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_LAST  = 11;
  localparam int ST_LONG  = 5;
  localparam int ST_TRUNC = 0;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [3:0] {
    S_IDLE, S_DB, S_CHK, S_BD0, S_BD1, S_BYTE, S_WB, S_NEXT, S_DRAIN
  } rx_state_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxbd_crc32.sv
module rxbd_crc32
  import rxbd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '1;
    else if (en)    acc <= crc_step(acc, din);
  end

  assign fcs = ~acc;

  // R6: a cleared accumulator presents a zero check value
  p_crc_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fcs == 32'd0));
endmodule

// File: rtl/rxbd_bufsz_reg.sv
module rxbd_bufsz_reg #(
  parameter int BSZ_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [BSZ_W-1:0] wdata,
  output logic [BSZ_W-1:0] bufsz
);
  localparam logic [BSZ_W-1:0] KEEP = {{(BSZ_W-4){1'b1}}, 4'b0000};
  logic [BSZ_W-1:0] masked;

  assign masked = wdata & KEEP;

  always_ff @(posedge clk) begin
    if (rst)     bufsz <= KEEP;
    else if (wr) bufsz <= (masked == '0) ? KEEP : masked;
  end

  // R11: a write that masks to zero falls back to the largest size
  p_bufsz_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (wr && masked == '0) |=> (bufsz == KEEP));
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 16,
  parameter int HARD_CAP = 2032,
  parameter int BSZ_W    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              ring_base_wr,
  input  logic [ADDR_W-4:0] ring_base_data,
  input  logic              bufsz_wr,
  input  logic [BSZ_W-1:0]  bufsz_data,
  input  logic              doorbell,
  input  logic              hdr_valid,
  input  logic [LEN_W-1:0]  hdr_len,
  output logic              hdr_ready,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              rx_active,
  output logic              evt_buf,
  output logic              evt_frame
);
  localparam int SZ_W = LEN_W + 1;
  localparam logic [SZ_W-1:0] CAP_V = SZ_W'(HARD_CAP);
  localparam logic [SZ_W-1:0] CRC_N = SZ_W'(4);

  rx_state_t         state;
  logic [ADDR_W-1:0] ring_base, cur_ptr, walk_ptr, bptr;
  logic [SZ_W-1:0]   want, remain, dcnt, idx, boff;
  logic [LEN_W-1:0]  in_len, in_cnt, drain_left;
  logic [15:0]       bd_stat;
  logic              flg_lg, flg_tr;
  logic [BSZ_W-1:0]  bufsz;
  logic [31:0]       fcs;

  // header decode
  logic [SZ_W-1:0] size_raw, size_c, bsz_ext, chunk_c;
  logic            hdr_tr, hdr_lg, last_c, hdr_take, byte_take;
  logic [ADDR_W-1:0] next_ptr, walk_next;
  logic [1:0]      crc_sel;
  logic [7:0]      crc_byte;
  logic [15:0]     new_stat;

  assign size_raw  = {1'b0, hdr_len} + CRC_N;
  assign hdr_tr    = size_raw > CAP_V;
  assign size_c    = hdr_tr ? CAP_V : size_raw;
  assign hdr_lg    = hdr_tr || (size_c > {1'b0, cfg_max_len});
  assign bsz_ext   = SZ_W'(bufsz);
  assign last_c    = remain <= bsz_ext;
  assign chunk_c   = last_c ? remain : bsz_ext;
  assign next_ptr  = bd_stat[ST_WRAP] ? ring_base : cur_ptr + ADDR_W'(8);
  assign walk_next = mem_rdata[16+ST_WRAP] ? ring_base : walk_ptr + ADDR_W'(8);
  assign crc_sel   = 2'(idx - dcnt);
  assign crc_byte  = 8'(fcs >> {crc_sel, 3'b000});

  always_comb begin
    new_stat = bd_stat & ~(16'd1 << ST_EMPTY);
    if (last_c) begin
      new_stat[ST_LAST]  = 1'b1;
      new_stat[ST_LONG]  = flg_lg;
      new_stat[ST_TRUNC] = flg_tr;
    end
  end

  assign hdr_ready = (state == S_IDLE) && cfg_enable && rx_active;
  assign hdr_take  = hdr_valid && hdr_ready;
  assign s_ready   = ((state == S_BYTE) && !mem_req && (idx < dcnt)) ||
                     ((state == S_DRAIN) && (drain_left != '0));
  assign byte_take = (state == S_BYTE) && s_ready && s_valid;

  rxbd_bufsz_reg #(.BSZ_W(BSZ_W)) u_bufsz (
    .clk(clk), .rst(rst), .wr(bufsz_wr), .wdata(bufsz_data), .bufsz(bufsz)
  );

  rxbd_crc32 u_crc (
    .clk(clk), .rst(rst), .clr(hdr_take), .en(byte_take), .din(s_data), .fcs(fcs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ring_base  <= '0;
      cur_ptr    <= '0;
      walk_ptr   <= '0;
      bptr       <= '0;
      want       <= '0;
      remain     <= '0;
      dcnt       <= '0;
      idx        <= '0;
      boff       <= '0;
      in_len     <= '0;
      in_cnt     <= '0;
      drain_left <= '0;
      bd_stat    <= '0;
      flg_lg     <= 1'b0;
      flg_tr     <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_be     <= '0;
      rx_active  <= 1'b0;
      evt_buf    <= 1'b0;
      evt_frame  <= 1'b0;
    end else begin
      evt_buf   <= 1'b0;
      evt_frame <= 1'b0;
      if (!cfg_enable) rx_active <= 1'b0;
      if (ring_base_wr) begin
        ring_base <= {ring_base_data, 3'b000};
        cur_ptr   <= {ring_base_data, 3'b000};
      end
      case (state)
        S_IDLE: begin
          if (hdr_take) begin
            in_len   <= hdr_len;
            in_cnt   <= '0;
            want     <= size_c;
            remain   <= size_c;
            dcnt     <= size_c - CRC_N;
            flg_lg   <= hdr_lg;
            flg_tr   <= hdr_tr;
            idx      <= '0;
            walk_ptr <= cur_ptr;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_ptr;
            mem_be   <= 4'hF;
            state    <= S_CHK;
          end else if (doorbell && cfg_enable && !rx_active) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_ptr;
            mem_be   <= 4'hF;
            state    <= S_DB;
          end
        end
        S_DB: if (mem_ack) begin
          mem_req   <= 1'b0;
          rx_active <= mem_rdata[16+ST_EMPTY] && cfg_enable;
          state     <= S_IDLE;
        end
        S_CHK: if (mem_ack) begin
          if (!mem_rdata[16+ST_EMPTY]) begin
            mem_req    <= 1'b0;
            drain_left <= in_len;
            state      <= S_DRAIN;
          end else if (want <= bsz_ext) begin
            mem_addr <= cur_ptr;
            state    <= S_BD0;
          end else begin
            want     <= want - bsz_ext;
            walk_ptr <= walk_next;
            mem_addr <= walk_next;
          end
        end
        S_BD0: if (mem_ack) begin
          bd_stat  <= mem_rdata[31:16];
          mem_addr <= cur_ptr + ADDR_W'(4);
          state    <= S_BD1;
        end
        S_BD1: if (mem_ack) begin
          bptr    <= mem_rdata[ADDR_W-1:0];
          boff    <= '0;
          mem_req <= 1'b0;
          state   <= S_BYTE;
        end
        S_BYTE: begin
          if (mem_req) begin
            if (mem_ack) begin
              idx  <= idx + 1'b1;
              boff <= boff + 1'b1;
              if (boff + 1'b1 == chunk_c) begin
                mem_we    <= 1'b1;
                mem_addr  <= cur_ptr;
                mem_wdata <= {new_stat, 16'(chunk_c)};
                mem_be    <= 4'hF;
                state     <= S_WB;
              end else begin
                mem_req <= 1'b0;
              end
            end
          end else if (idx < dcnt) begin
            if (s_valid) begin
              in_cnt    <= in_cnt + 1'b1;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= bptr + ADDR_W'(boff);
              mem_wdata <= {4{s_data}};
              mem_be    <= 4'b0001 << (bptr[1:0] + boff[1:0]);
            end
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= bptr + ADDR_W'(boff);
            mem_wdata <= {4{crc_byte}};
            mem_be    <= 4'b0001 << (bptr[1:0] + boff[1:0]);
          end
        end
        S_WB: if (mem_ack) begin
          remain   <= remain - chunk_c;
          cur_ptr  <= next_ptr;
          mem_we   <= 1'b0;
          mem_addr <= next_ptr;
          mem_be   <= 4'hF;
          if (last_c) begin
            evt_frame <= 1'b1;
            state     <= S_NEXT;
          end else begin
            evt_buf <= 1'b1;
            state   <= S_BD0;
          end
        end
        S_NEXT: if (mem_ack) begin
          mem_req   <= 1'b0;
          rx_active <= mem_rdata[16+ST_EMPTY] && cfg_enable;
          if (in_cnt != in_len) begin
            drain_left <= in_len - in_cnt;
            state      <= S_DRAIN;
          end else begin
            state <= S_IDLE;
          end
        end
        S_DRAIN: begin
          if (drain_left == '0)  state <= S_IDLE;
          else if (s_valid)      drain_left <= drain_left - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a descriptor completes either as a buffer or as a frame end
  p_evt_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(evt_buf && evt_frame));
  // R5: a pending memory request keeps its address and direction
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R12: frame completion is followed by a read of the next descriptor
  p_frame_then_read_r12: assert property (@(posedge clk) disable iff (rst)
    evt_frame |-> (mem_req && !mem_we));
  // R3: dropping the enable clears reception
  p_enable_drop_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !rx_active);
  // R4: the space walk only reads
  p_walk_reads_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHK) |-> !mem_we);
  // R8: no stored byte lies beyond the hard cap
  p_cap_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_BYTE && mem_req && mem_ack) |-> (idx < CAP_V));
  // R5: a written-back count is non-zero and within one buffer
  p_wb_len_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB && mem_req) |-> (mem_wdata[15:0] != 16'd0 &&
                                    SZ_W'(mem_wdata[15:0]) <= bsz_ext));
endmodule

// File: tb/sim_rxbd_engine.sv
module sim_rxbd_engine;
  localparam int AW = 32, LW = 16, CAP = 96, BW = 11, NSLOT = 8;
  localparam int RING = 32'h100, BUF0 = 32'h400;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_enable = 1'b0;
  logic [LW-1:0] cfg_max_len = 16'd1000;
  logic ring_base_wr = 1'b0;
  logic [AW-4:0] ring_base_data = '0;
  logic bufsz_wr = 1'b0;
  logic [BW-1:0] bufsz_data = '0;
  logic doorbell = 1'b0, hdr_valid = 1'b0, s_valid = 1'b0;
  logic [LW-1:0] hdr_len = '0;
  logic [7:0] s_data = '0;
  logic hdr_ready, s_ready, mem_req, mem_we, rx_active, evt_buf, evt_frame;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;

  rxbd_engine #(.ADDR_W(AW), .LEN_W(LW), .HARD_CAP(CAP), .BSZ_W(BW)) u0 (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_max_len(cfg_max_len),
    .ring_base_wr(ring_base_wr), .ring_base_data(ring_base_data),
    .bufsz_wr(bufsz_wr), .bufsz_data(bufsz_data), .doorbell(doorbell),
    .hdr_valid(hdr_valid), .hdr_len(hdr_len), .hdr_ready(hdr_ready),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .rx_active(rx_active), .evt_buf(evt_buf), .evt_frame(evt_frame));

  always #5 clk = ~clk;

  logic [7:0] mem [0:4095];
  int wr_count = 0, nbuf = 0, nframe = 0;
  int checks = 0, fails = 0, mslot = 0;

  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        wr_count = wr_count + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_addr[11:2], 2'(b)}] = mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= {mem[mem_addr[11:0]+3], mem[mem_addr[11:0]+2],
                      mem[mem_addr[11:0]+1], mem[mem_addr[11:0]]};
      end
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    if (evt_buf)   nbuf   <= nbuf + 1;
    if (evt_frame) nframe <= nframe + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] get32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic rearm();
    for (int s = 0; s < NSLOT; s++) begin
      put32(RING + 8*s, {16'h8000 | ((s == NSLOT-1) ? 16'h2000 : 16'h0), 16'h0});
      put32(RING + 8*s + 4, BUF0 + s*64);
    end
  endtask

  function automatic logic [7:0] pat(input int len, input int j);
    return 8'((len*7 + j*13 + 5) & 255);
  endfunction

  function automatic logic [31:0] crc_of(input int len, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int j = 0; j < n; j++) begin
      c = c ^ {24'd0, pat(len, j)};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ring_doorbell();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
    cycles(10);
  endtask

  // dbmode 1: doorbell with header; dbmode 2: doorbell during data
  task automatic send(input int len, input int dbmode);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_len = LW'(len);
    if (dbmode == 1) doorbell = 1'b1;
    while (!hdr_ready) begin @(negedge clk); doorbell = 1'b0; end
    @(negedge clk);
    hdr_valid = 1'b0; doorbell = 1'b0;
    for (int j = 0; j < len; j++) begin
      s_valid = 1'b1; s_data = pat(len, j);
      if (dbmode == 2 && j == 3) doorbell = 1'b1;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      doorbell = 1'b0;
    end
    s_valid = 1'b0;
  endtask

  task automatic run_frame(input int len, input int bsz, input int maxl,
                           input bit exp_act, input string tag, input int dbmode);
    int w0, b0, f0, size, dcnt, nd, slot, off, elen, bad_len, bad_st, bad_dat;
    bit tr, lg;
    logic [15:0] est, ast;
    logic [7:0] eb;
    logic [31:0] fcs;
    w0 = wr_count; b0 = nbuf; f0 = nframe;
    send(len, dbmode);
    cycles(80);
    size = len + 4;
    tr = size > CAP;
    if (tr) size = CAP;
    dcnt = size - 4;
    lg = tr || (size > maxl);
    nd = (size + bsz - 1) / bsz;
    fcs = crc_of(len, dcnt);
    bad_len = 0; bad_st = 0; bad_dat = 0;
    for (int k = 0; k < nd; k++) begin
      slot = (mslot + k) % NSLOT;
      elen = (size - k*bsz < bsz) ? size - k*bsz : bsz;
      est = ((slot == NSLOT-1) ? 16'h2000 : 16'h0) |
            ((k == nd-1) ? (16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0)) : 16'h0);
      ast = get32(RING + 8*slot) >> 16;
      if (get32(RING + 8*slot) % 65536 != elen) bad_len++;
      if (ast != est) bad_st++;
    end
    for (int j = 0; j < size; j++) begin
      slot = (mslot + j / bsz) % NSLOT;
      off = j % bsz;
      eb = (j < dcnt) ? pat(len, j) : fcs[8*(j-dcnt) +: 8];
      if (mem[BUF0 + slot*64 + off] != eb) bad_dat++;
    end
    chk(bad_len == 0, "R5 length field", bad_len, 0);
    chk(bad_st == 0, tag, bad_st, 0);
    chk(bad_dat == 0, "R6 R10 stored bytes", bad_dat, 0);
    chk(wr_count - w0 == size + nd, "R5 write count", wr_count - w0, size + nd);
    chk(nbuf - b0 == nd - 1, "R7 buffer events", nbuf - b0, nd - 1);
    chk(nframe - f0 == 1, "R7 frame events", nframe - f0, 1);
    chk(rx_active == exp_act, "R12 active after frame", int'(rx_active), int'(exp_act));
    mslot = (mslot + nd) % NSLOT;
  endtask

  task automatic set_bufsz(input int v);
    @(negedge clk); bufsz_wr = 1'b1; bufsz_data = BW'(v);
    @(negedge clk); bufsz_wr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int w0, b0, f0, sl;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    cycles(5);
    chk(!rx_active && !hdr_ready && !mem_req && !evt_buf && !evt_frame,
        "R1 reset state", int'({rx_active, hdr_ready, mem_req, evt_buf, evt_frame}), 0);
    rst = 1'b0;
    cycles(2);
    chk(!rx_active && !mem_req, "R1 after release", int'({rx_active, mem_req}), 0);
    @(negedge clk); ring_base_wr = 1'b1; ring_base_data = (AW-3)'(RING / 8);
    @(negedge clk); ring_base_wr = 1'b0;
    set_bufsz(16);
    cfg_enable = 1'b1;
    rearm();
    ring_doorbell();
    chk(rx_active, "R2 doorbell arms", int'(rx_active), 1);

    for (int len = 0; len <= 100; len++) begin
      rearm();
      run_frame(len, 16, 1000, 1'b1, (len + 4 > CAP) ? "R8 trunc status" : "R7 status", 0);
    end

    cfg_max_len = 16'd50;
    rearm(); run_frame(46, 16, 50, 1'b1, "R9 at limit", 0);
    rearm(); run_frame(47, 16, 50, 1'b1, "R9 over limit", 0);
    cfg_max_len = 16'd1000;

    set_bufsz(12'h25 & 11'h7FF);
    rearm(); run_frame(60, 32, 1000, 1'b1, "R11 masked size", 0);
    for (int len = 0; len <= 100; len += 7) begin
      rearm(); run_frame(len, 32, 1000, 1'b1, "R7 status wide", 0);
    end
    set_bufsz(16'h0F);
    rearm(); run_frame(50, 32'h7F0, 1000, 1'b1, "R11 zero mask", 0);
    set_bufsz(0);
    rearm(); run_frame(20, 32'h7F0, 1000, 1'b1, "R11 zero write", 0);
    set_bufsz(16);

    // R4: blocked within reach, frame dropped whole
    rearm();
    sl = (mslot + 1) % NSLOT;
    mem[RING + 8*sl + 3] = mem[RING + 8*sl + 3] & 8'h7F;
    w0 = wr_count; b0 = nbuf; f0 = nframe;
    send(30, 0);
    cycles(40);
    chk(wr_count == w0, "R4 drop writes", wr_count - w0, 0);
    chk(nbuf == b0 && nframe == f0, "R4 drop events", nbuf - b0 + nframe - f0, 0);
    chk(rx_active, "R4 still active after drop", int'(rx_active), 1);
    // R4 exact fit, R12 next slot not empty
    rearm();
    sl = (mslot + 2) % NSLOT;
    mem[RING + 8*sl + 3] = mem[RING + 8*sl + 3] & 8'h7F;
    run_frame(28, 16, 1000, 1'b0, "R4 exact fit", 0);
    chk(!hdr_ready, "R12 header refused", int'(hdr_ready), 0);

    // R3
    rearm();
    cfg_enable = 1'b0;
    cycles(3);
    chk(!rx_active, "R3 disable clears", int'(rx_active), 0);
    ring_doorbell();
    chk(!rx_active, "R3 doorbell ignored", int'(rx_active), 0);
    cfg_enable = 1'b1;
    cycles(2);
    chk(!rx_active, "R3 enable alone", int'(rx_active), 0);

    // doorbell with header while inactive, then doorbell during data
    rearm();
    run_frame(40, 16, 1000, 1'b1, "R2 doorbell with header", 1);
    rearm();
    run_frame(70, 16, 1000, 1'b1, "R2 doorbell mid frame", 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule